// File: doc/BRIEF.md
# Phase-Shifted Full-Bridge PWM Generator

This block produces the four gate commands for a full-bridge power stage. A period counter counts up to a terminal value and wraps; each wrap, or a sync pulse from outside, is a period boundary. The first leg's pair (A, B) toggles at every boundary, so each of its outputs is a 50% square wave at half the boundary rate. The second leg's pair (C, D) is a delayed copy of the first. The delay is set by a digital duty command, compared against the counter ramp. This phase shift, not a pulse width, sets the power delivered to the load.

A peak-current flag ends the delay early within the current half period. A disable input forces all four outputs low at once. The sync pin is split into an input that restarts the ramp and an output that presents each boundary as a one-cycle pulse, so several generators can run in lockstep. The duty command is a level that is sampled only at boundaries. It therefore has no handshake: whatever value is present at a boundary is used for the next half period. Dead-time insertion between the two outputs of a leg happens downstream.

Top module: `psfb_pwm_core`

## Requirements
- R1: With `en` held high and no sync input, the counter runs 0 to TERM and wraps, so a boundary occurs every TERM+1 clocks. `out_a` changes level at every boundary and at no other time, giving a period of 2·(TERM+1) clocks.
- R2: While `dis` is low, `out_b` is the inverse of `out_a` and `out_d` is the inverse of `out_c`. After reset A and C are low, so B and D are high.
- R3: While `en` is low and `sync_in` is low, the counter holds its value, so no boundary occurs and `out_a` and `sync_out` stay unchanged.
- R4: A duty command of 0 at a boundary gives zero phase shift: `out_c` equals `out_a` for the whole following half period.
- R5: A duty command d with 1 ≤ d ≤ TERM, sampled at a boundary, makes `out_c` differ from `out_a` for the first d clocks of the half period and match it afterwards. For any d ≥ TERM+1 they differ for the whole half period (full shift, C is the inverse of A).
- R6: The duty command is sampled only at a boundary. A change between boundaries has no effect until the next boundary.
- R7: A high `ilim` in a cycle that is not a boundary makes `out_c` take the level of `out_a` at the following clock edge, ending the delay early.
- R8: A high `sync_in` is a boundary whatever the counter value and whatever `en` is. The counter restarts at 0 and `out_a` toggles at that edge.
- R9: `sync_out` is high for exactly one clock after every boundary (the cycle in which the counter reads 0) and is low otherwise.
- R10: While `dis` is high, all four outputs are low in the same cycle. Internal timing keeps running, and the outputs resume from it when `dis` falls.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| en | input | 1 | Counter advance enable |
| sync_in | input | 1 | External boundary request; restarts the ramp |
| sync_out | output | 1 | One-cycle pulse after each boundary |
| duty_cmd | input | CNT_W | Phase-shift command in clocks, sampled at boundaries |
| ilim | input | 1 | Peak-current flag; ends the leg-2 delay early |
| dis | input | 1 | Fault/disable; forces all outputs low |
| out_a | output | 1 | Leg 1 upper command |
| out_b | output | 1 | Leg 1 lower command |
| out_c | output | 1 | Leg 2 upper command |
| out_d | output | 1 | Leg 2 lower command |

## Verification
Every state change lands on the clock edge that ends a boundary cycle. `sync_out` and A's new level are therefore visible in the first cycle after it, and C's switch in cycle index d of the half period. A `sync_in` or `ilim` driven in one cycle shows on the outputs in the next cycle, while `dis` acts on the outputs in the same cycle. The bench drives inputs on the falling edge and samples on the following falling edge. It locks onto `sync_out` to learn the cycle index within each half period, and compares each sampled cycle against the index-based expectation.

// File: rtl/psfb_pkg.sv
package psfb_pkg;
  localparam int unsigned LEGS = 2;

  typedef struct packed {
    logic hi;
    logic lo;
  } pair_t;
endpackage

// File: rtl/psfb_ramp.sv
module psfb_ramp #(
  parameter int unsigned CNT_W = 8,
  parameter int unsigned TERM  = 199
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             sync_in,
  output logic [CNT_W-1:0] cnt_q,
  output logic             tick,
  output logic             sync_out
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(TERM);
  localparam logic [CNT_W-1:0] STEP = CNT_W'(1);

  // boundary: external request or terminal count reached while running
  assign tick = sync_in | (en & (cnt_q == LAST));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q    <= '0;
      sync_out <= 1'b0;
    end else begin
      sync_out <= tick;
      if (tick)
        cnt_q <= '0;
      else if (en)
        cnt_q <= cnt_q + STEP;
    end
  end
endmodule

// File: rtl/psfb_phase.sv
module psfb_phase #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic [CNT_W-1:0] cnt_q,
  input  logic [CNT_W-1:0] duty_cmd,
  input  logic             ilim,
  output logic             ph_a,
  output logic             ph_c
);
  localparam logic [CNT_W-1:0] STEP = CNT_W'(1);

  logic [CNT_W-1:0] duty_q;
  logic [CNT_W-1:0] hit_pt;
  logic             cmd_zero;

  // leg 2 catches up at the edge that ends cycle d-1
  assign hit_pt   = duty_q - STEP;
  assign cmd_zero = (duty_cmd == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ph_a   <= 1'b0;
      ph_c   <= 1'b0;
      duty_q <= '0;
    end else if (tick) begin
      ph_a   <= ~ph_a;
      duty_q <= duty_cmd;
      // zero command follows A at once; otherwise finish any open delay
      ph_c   <= cmd_zero ? ~ph_a : ph_a;
    end else if (ilim || (cnt_q == hit_pt)) begin
      ph_c <= ph_a;
    end
  end
endmodule

// File: rtl/psfb_pair.sv
module psfb_pair
  import psfb_pkg::*;
(
  input  logic  phase,
  input  logic  kill,
  output pair_t drv
);
  always_comb begin
    drv.hi = phase & ~kill;
    drv.lo = ~phase & ~kill;
  end
endmodule

// File: rtl/psfb_pwm_core.sv
module psfb_pwm_core
  import psfb_pkg::*;
#(
  parameter int unsigned CNT_W = 8,
  parameter int unsigned TERM  = 199
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             sync_in,
  output logic             sync_out,
  input  logic [CNT_W-1:0] duty_cmd,
  input  logic             ilim,
  input  logic             dis,
  output logic             out_a,
  output logic             out_b,
  output logic             out_c,
  output logic             out_d
);
  logic [CNT_W-1:0] cnt_q;
  logic             tick;
  logic             ph_a;
  logic             ph_c;
  logic [LEGS-1:0]  leg_ph;
  pair_t            leg_drv [LEGS];

  psfb_ramp #(.CNT_W(CNT_W), .TERM(TERM)) u_ramp (
    .clk(clk), .rst_n(rst_n), .en(en), .sync_in(sync_in),
    .cnt_q(cnt_q), .tick(tick), .sync_out(sync_out)
  );

  psfb_phase #(.CNT_W(CNT_W)) u_phase (
    .clk(clk), .rst_n(rst_n), .tick(tick), .cnt_q(cnt_q),
    .duty_cmd(duty_cmd), .ilim(ilim), .ph_a(ph_a), .ph_c(ph_c)
  );

  assign leg_ph = {ph_c, ph_a};

  for (genvar g = 0; g < LEGS; g++) begin : g_leg
    psfb_pair u_pair (.phase(leg_ph[g]), .kill(dis), .drv(leg_drv[g]));
  end

  assign out_a = leg_drv[0].hi;
  assign out_b = leg_drv[0].lo;
  assign out_c = leg_drv[1].hi;
  assign out_d = leg_drv[1].lo;
endmodule

// File: rtl/psfb_pwm_chk.sv
module psfb_pwm_chk #(
  parameter int unsigned CNT_W = 8,
  parameter int unsigned TERM  = 199
) (
  input logic             clk,
  input logic             rst_n,
  input logic             en,
  input logic             sync_in,
  input logic             sync_out,
  input logic [CNT_W-1:0] duty_cmd,
  input logic             ilim,
  input logic             dis,
  input logic [CNT_W-1:0] cnt_q,
  input logic             ph_a,
  input logic             ph_c,
  input logic             out_a,
  input logic             out_b,
  input logic             out_c,
  input logic             out_d
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(TERM);

  logic bnd;
  assign bnd = sync_in | (en & (cnt_q == LAST));

  AST_WRAP_AT_TERM: assert property (@(posedge clk) disable iff (!rst_n)
    (en && cnt_q == LAST) |=> (cnt_q == '0)); // R1
  AST_A_TOGGLES: assert property (@(posedge clk) disable iff (!rst_n)
    bnd |=> !$stable(ph_a)); // R1
  AST_A_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !bnd |=> $stable(ph_a)); // R1
  AST_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !sync_in) |=> $stable(cnt_q)); // R3
  AST_ZERO_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
    (bnd && duty_cmd == '0) |=> (ph_c == ph_a)); // R4
  AST_ILIM_CATCHUP: assert property (@(posedge clk) disable iff (!rst_n)
    (!bnd && ilim) |=> (ph_c == ph_a)); // R7
  AST_SYNC_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    sync_in |=> (cnt_q == '0 && sync_out)); // R8
  AST_SYNC_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !bnd |=> !sync_out); // R9
  AST_DIS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    dis |-> !(out_a || out_b || out_c || out_d)); // R10
endmodule

bind psfb_pwm_core psfb_pwm_chk #(.CNT_W(CNT_W), .TERM(TERM)) u_chk (
  .clk(clk), .rst_n(rst_n), .en(en), .sync_in(sync_in), .sync_out(sync_out),
  .duty_cmd(duty_cmd), .ilim(ilim), .dis(dis), .cnt_q(cnt_q),
  .ph_a(ph_a), .ph_c(ph_c), .out_a(out_a), .out_b(out_b),
  .out_c(out_c), .out_d(out_d)
);

// File: tb/sim_psfb_pwm_core.sv
module sim_psfb_pwm_core;
  localparam int CLK_P = 10;
  localparam int CW    = 4;
  localparam int TRM   = 5;
  localparam int N     = TRM + 1;

  logic clk = 1'b0;
  logic rst_n, en, sync_in, ilim, dis;
  logic [CW-1:0] duty_cmd;
  logic sync_out, out_a, out_b, out_c, out_d;
  int nchk = 0;
  int nfail = 0;

  always #(CLK_P/2) clk = ~clk;

  psfb_pwm_core #(.CNT_W(CW), .TERM(TRM)) u0 (
    .clk(clk), .rst_n(rst_n), .en(en), .sync_in(sync_in), .sync_out(sync_out),
    .duty_cmd(duty_cmd), .ilim(ilim), .dis(dis),
    .out_a(out_a), .out_b(out_b), .out_c(out_c), .out_d(out_d)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic sync_up();
    do @(negedge clk); while (!sync_out);
  endtask

  // Called at the falling edge of cycle 0 of a half period.
  // eff: clocks C should differ from A; ilim_k/chg_k: cycle to pulse ilim / change duty.
  task automatic check_half(input int eff, input int ilim_k, input int chg_k, input int chg_v);
    logic a0;
    a0 = out_a;
    for (int k = 0; k < N; k++) begin
      chk(sync_out == (k == 0), "R9 sync_out vs cycle index", sync_out, k == 0);
      chk(out_a == a0, "R1 A steady inside half", out_a, a0);
      chk(out_b == !out_a && out_d == !out_c, "R2 pair complement", {out_b, out_d}, {!out_a, !out_c});
      chk((out_a != out_c) == (k < eff), "R5 C lag pattern", out_a != out_c, k < eff);
      ilim = (k == ilim_k);
      if (k == chg_k) duty_cmd = CW'(chg_v);
      @(negedge clk);
    end
    ilim = 1'b0;
    chk(out_a != a0, "R1 A toggles at boundary", out_a, !a0);
  endtask

  initial begin
    logic a_rec;
    rst_n = 1'b0; en = 1'b1; sync_in = 1'b0; ilim = 1'b0; dis = 1'b0; duty_cmd = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    chk(out_a == 0 && out_b == 1 && out_c == 0 && out_d == 1 && sync_out == 0,
        "R2 reset levels", {out_a, out_b, out_c, out_d}, 4'b0101);

    // R4 and R5: sweep every duty value, including values past full shift
    for (int d = 0; d <= N + 2; d++) begin
      duty_cmd = CW'(d);
      sync_up();
      check_half((d < N) ? d : N, -1, -1, 0);
      check_half((d < N) ? d : N, -1, -1, 0);
      if (d == 0) chk(out_a == out_c, "R4 zero shift", out_c, out_a);
    end

    // R6: change mid-period, old value still applies until next boundary
    duty_cmd = CW'(2);
    sync_up();
    check_half(2, -1, 0, 5);
    check_half(5, -1, -1, 0);

    // R7: current flag at cycle 2 of a full-shift half ends the delay after 3 clocks
    duty_cmd = CW'(N);
    sync_up();
    check_half(3, 2, -1, 0);
    check_half(N, -1, -1, 0);

    // R8: sync input restarts the ramp mid-period
    duty_cmd = CW'(3);
    sync_up();
    a_rec = out_a;
    @(negedge clk);
    sync_in = 1'b1;
    @(negedge clk);
    sync_in = 1'b0;
    chk(sync_out == 1'b1, "R8 restart pulse", sync_out, 1);
    chk(out_a != a_rec, "R8 A toggles on sync", out_a, !a_rec);
    check_half(3, -1, -1, 0);

    // R3: counter stalls without enable
    en = 1'b0;
    a_rec = out_a;
    for (int i = 0; i < 3 * N; i++) begin
      @(negedge clk);
      chk(sync_out == 1'b0 && out_a == a_rec, "R3 stall", {sync_out, out_a}, {1'b0, a_rec});
    end
    en = 1'b1;
    sync_up();
    check_half(3, -1, -1, 0);

    // R10: disable forces all outputs low in the same cycle
    dis = 1'b1;
    #1;
    chk({out_a, out_b, out_c, out_d} == 4'b0, "R10 immediate low", {out_a, out_b, out_c, out_d}, 0);
    for (int i = 0; i < 2 * N; i++) begin
      @(negedge clk);
      chk({out_a, out_b, out_c, out_d} == 4'b0, "R10 held low", {out_a, out_b, out_c, out_d}, 0);
    end
    dis = 1'b0;
    #1;
    chk(out_b == !out_a && out_d == !out_c, "R10 resume", {out_b, out_d}, {!out_a, !out_c});
    sync_up();
    check_half(3, -1, -1, 0);

    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end

  initial begin
    #(CLK_P * 150000);
    nfail++;
    $display("FAIL watchdog R1 actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end
endmodule